// File: doc/BRIEF.md
# Debug Trace Capture Controller

This block is an on-chip trace unit for a small processor core. While a debug run is armed it compares each valid bus address against two programmable comparator addresses. It stores bus data words in a small circular trace buffer. It offers two capture styles. In begin-trace mode, recording starts at the trigger word and the run stops once the buffer is full. In end-trace mode, recording runs all the time, the oldest entry is overwritten, and the run stops on the trigger word.

A host programs the unit through a narrow write port. That port carries a control word (enable, arm, capture style, trigger style) and the two comparator addresses. The host watches a read-only status word and then drains the buffer, oldest word first. The valid-count field in the status word is frozen at the end of a run. Draining the buffer does not lower it, so the host keeps its own tally of the words it has read.

Top module: `dbg_trace_top`

## Requirements
- R1: A control write with the arm bit set and the enable bit clear leaves the armed status flag at 0.
- R2: A control write with enable and arm both set, made while no run is active, starts a run. On the next cycle the armed flag is 1 and both match flags and the valid count are 0.
- R3: In begin-trace mode, nothing is stored before the trigger. The trigger word is stored first. The run ends, with the armed flag clearing, on the same clock edge that stores the eighth word. Later words are not stored.
- R4: In end-trace mode, every valid bus word is stored while armed. Past eight words the oldest entry is overwritten and the count stays at 8. The trigger word is stored last and ends the run.
- R5: A control write with arm clear or enable clear ends an active run. The count then stays fixed, and later bus traffic is not stored.
- R6: While armed, a match flag is set by a comparator hit on any cycle where bus_valid is 1. It stays set until the next run starts. Cycles with bus_valid at 0 are ignored.
- R7: Control bit 3 selects the trigger. At 0 the trigger is a comparator A hit. At 1 the trigger is a comparator B hit on a cycle after an earlier A hit in the same run. A B hit before any A hit does not trigger.
- R8: The status word packs the A flag in bit 7, the B flag in bit 6, the armed flag in bit 5, a constant 0 in bit 4, and the valid count (0 to 8, binary) in bits 3:0.
- R9: After a run, each rd_en pulse returns the next stored word on rd_data one cycle later, oldest first.
- R10: Reads never lower the valid count. A read after all counted words have been returned, or a read made while armed, returns 0 and changes no state.
- R11: After reset, status and rd_data are 0.
- R12: wr_sel 0 writes the control word: bit 0 enable, bit 1 arm, bit 2 capture style (1 = begin-trace, 0 = end-trace), bit 3 trigger style. wr_sel 1 loads comparator A, wr_sel 2 loads comparator B, and wr_sel 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | AW (16) | Write data |
| bus_valid | input | 1 | Bus cycle qualifier |
| bus_addr | input | AW (16) | Observed bus address |
| bus_data | input | DW (8) | Observed bus data word |
| status | output | CW+4 (8) | Flags and valid count |
| rd_en | input | 1 | Trace buffer read strobe |
| rd_data | output | DW (8) | Word returned by a read |

## Verification
The hardest state to reach is a wrapped end-trace buffer whose read order must begin partway through storage. The bench gets there by streaming more than eight words. It places a B hit before any A hit, which must not trigger, and then an A hit followed by a B hit. It then checks that the last eight words come back in order. The begin-trace run is also driven past its full point, to show that words after the eighth are dropped and that the frozen count survives the drain and an extra read.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMPA = 2'd1,
    SEL_CMPB = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  localparam int CB_EN   = 0;
  localparam int CB_ARM  = 1;
  localparam int CB_MODE = 2;
  localparam int CB_TSEL = 3;

  typedef struct packed {
    logic en;
    logic begin_mode;
    logic seq_ab;
  } ctrl_t;

endpackage

// File: rtl/dbg_trace_ctl.sv
module dbg_trace_ctl
  import dbg_trace_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          end_evt,
  output ctrl_t         ctrl,
  output logic          armed,
  output logic          start,
  output logic [AW-1:0] cmp_a,
  output logic [AW-1:0] cmp_b
);

  logic ctl_wr;
  logic stop_wr;

  assign ctl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign stop_wr = ctl_wr && !(wr_data[CB_EN] && wr_data[CB_ARM]);
  assign start   = ctl_wr && wr_data[CB_EN] && wr_data[CB_ARM] && !armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      cmp_a <= '0;
      cmp_b <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: begin
          ctrl.en         <= wr_data[CB_EN];
          ctrl.begin_mode <= wr_data[CB_MODE];
          ctrl.seq_ab     <= wr_data[CB_TSEL];
        end
        SEL_CMPA: cmp_a <= wr_data;
        SEL_CMPB: cmp_b <= wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           armed <= 1'b0;
    else if (stop_wr)  armed <= 1'b0;
    else if (start)    armed <= 1'b1;
    else if (end_evt)  armed <= 1'b0;
  end

  // R1: a run can only be live while the enable bit is held
  p_arm_needs_en_r1: assert property (@(posedge clk) disable iff (rst)
    armed |-> ctrl.en);

  // R3 / R4: a run-ending event always drops the armed flag
  p_end_disarms_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && end_evt) |=> !armed);

  // R5: a stop write always drops the armed flag
  p_stop_disarms_r5: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> !armed);

endmodule

// File: rtl/dbg_trace_cmp.sv
module dbg_trace_cmp #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          armed,
  input  logic          seq_ab,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] cmp_a,
  input  logic [AW-1:0] cmp_b,
  output logic          flag_a,
  output logic          flag_b,
  output logic          seen,
  output logic          trig
);

  logic hit_a, hit_b, live;

  assign live  = armed && bus_valid;
  assign hit_a = live && (bus_addr == cmp_a);
  assign hit_b = live && (bus_addr == cmp_b);
  assign trig  = seq_ab ? (hit_b && flag_a) : hit_a;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
      seen   <= 1'b0;
    end else begin
      if (hit_a) flag_a <= 1'b1;
      if (hit_b) flag_b <= 1'b1;
      if (trig)  seen   <= 1'b1;
    end
  end

  // R6: flags hold until a new run starts
  p_flag_a_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_a && !start) |=> flag_a);
  p_flag_b_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_b && !start) |=> flag_b);
  // R6: a flag rises only from a qualified, armed bus cycle
  p_flag_a_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_a) |-> $past(armed && bus_valid));

endmodule

// File: rtl/dbg_trace_buf.sv
module dbg_trace_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          armed,
  input  logic          cap,
  input  logic          begin_mode,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [CW-1:0] cnt,
  output logic          full_evt,
  output logic [DW-1:0] rd_data
);

  localparam int PW = $clog2(DEPTH);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] rd_cnt;
  logic [PW-1:0] rd_idx;
  logic          rd_ok;

  assign full_evt = cap && begin_mode && (cnt == CNT_LAST);
  assign rd_ok    = rd_en && !armed && (rd_cnt < cnt);
  assign rd_idx   = wr_ptr - cnt[PW-1:0] + rd_cnt[PW-1:0];

  always_ff @(posedge clk) begin
    if (cap) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      wr_ptr <= '0;
      cnt    <= '0;
      rd_cnt <= '0;
    end else begin
      if (cap) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (rd_ok) rd_cnt <= rd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_ok) rd_data <= mem[rd_idx];
    else if (rd_en) rd_data <= '0;
  end

  // R4: the count never passes the buffer depth
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);
  // R10: once disarmed the count is frozen until the next start
  p_cnt_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (!armed && !start) |=> $stable(cnt));
  // R10: a read past the counted words yields zero
  p_dry_read_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !start && (armed || rd_cnt >= cnt)) |=> (rd_data == '0));

endmodule

// File: rtl/dbg_trace_top.sv
module dbg_trace_top
  import dbg_trace_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH) + 1,
  parameter int SW    = CW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic [SW-1:0] status,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data
);

  ctrl_t         ctrl;
  logic          armed, start, end_evt;
  logic [AW-1:0] cmp_a, cmp_b;
  logic          flag_a, flag_b, seen, trig;
  logic          cap, full_evt;
  logic [CW-1:0] cnt;

  assign cap     = armed && bus_valid && (!ctrl.begin_mode || seen || trig);
  assign end_evt = ctrl.begin_mode ? full_evt : trig;
  assign status  = {flag_a, flag_b, armed, 1'b0, cnt};

  dbg_trace_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .end_evt(end_evt), .ctrl(ctrl), .armed(armed), .start(start),
    .cmp_a(cmp_a), .cmp_b(cmp_b)
  );

  dbg_trace_cmp #(.AW(AW)) u_cmp (
    .clk(clk), .rst(rst), .start(start), .armed(armed), .seq_ab(ctrl.seq_ab),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .flag_a(flag_a), .flag_b(flag_b), .seen(seen), .trig(trig)
  );

  dbg_trace_buf #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_buf (
    .clk(clk), .rst(rst), .start(start), .armed(armed), .cap(cap),
    .begin_mode(ctrl.begin_mode), .wdata(bus_data), .rd_en(rd_en),
    .cnt(cnt), .full_evt(full_evt), .rd_data(rd_data)
  );

  // R8: bit 4 of the status word is always zero
  p_status_gap_r8: assert property (@(posedge clk) disable iff (rst)
    status[CW] == 1'b0);
  // R3: in begin-trace mode nothing is stored before the trigger
  p_no_pretrig_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && ctrl.begin_mode && !seen && !trig && !start) |=> $stable(cnt));

endmodule

// File: tb/tb_dbg_trace_top.sv
module tb_dbg_trace_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic [7:0]  status;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_trace_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .status(status), .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus(input logic v, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_valid = v; bus_addr = a; bus_data = d;
    @(negedge clk); bus_valid = 1'b0;
  endtask

  task automatic rd(input string tag, input int exp);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R11 status after reset", status, 0);
    chk("R11 rd_data after reset", rd_data, 0);
  endtask

  task automatic t_enable_gate();
    wr(2'd0, 16'h0002);
    chk("R1 arm without enable", status, 8'h00);
    wr(2'd3, 16'h0003);
    chk("R12 select 3 ignored", status, 8'h00);
  endtask

  task automatic t_begin();
    wr(2'd0, 16'h0007);
    chk("R2 run start status", status, 8'h20);
    for (int i = 0; i < 3; i++) bus(1'b1, 16'h0040, 8'h10 + 8'(i));
    chk("R3 nothing stored before trigger", status, 8'h20);
    bus(1'b1, 16'h0100, 8'hA0);
    chk("R8 status after trigger", status, 8'hA1);
    for (int i = 1; i < 10; i++) bus(1'b1, 16'h0040, 8'hA0 + 8'(i));
    chk("R3 full ends run", status, 8'h88);
    for (int i = 0; i < 8; i++) rd("R9 begin-trace read order", 8'hA0 + i);
    rd("R10 read past count", 0);
    chk("R10 count kept after drain", status, 8'h88);
  endtask

  task automatic t_end();
    wr(2'd0, 16'h000B);
    chk("R2 restart clears flags", status, 8'h20);
    bus(1'b1, 16'h0200, 8'h4F);
    chk("R7 B before A does not trigger", status, 8'h61);
    for (int i = 0; i < 12; i++) bus(1'b1, 16'h0030, 8'h50 + 8'(i));
    chk("R4 count saturates at 8", status, 8'h68);
    bus(1'b1, 16'h0100, 8'h70);
    chk("R7 A alone does not trigger in sequence mode", status, 8'hE8);
    bus(1'b1, 16'h0030, 8'h71);
    bus(1'b1, 16'h0030, 8'h72);
    bus(1'b1, 16'h0200, 8'h73);
    chk("R4 trigger ends end-trace run", status, 8'hC8);
    bus(1'b1, 16'h0030, 8'h74);
    chk("R4 no store after end", status, 8'hC8);
    rd("R4 oldest after wrap", 8'h58);
    rd("R4 wrap order", 8'h59);
    rd("R4 wrap order", 8'h5A);
    rd("R4 wrap order", 8'h5B);
    rd("R4 wrap order", 8'h70);
    rd("R4 wrap order", 8'h71);
    rd("R4 wrap order", 8'h72);
    rd("R4 trigger word last", 8'h73);
  endtask

  task automatic t_manual();
    wr(2'd0, 16'h0003);
    for (int i = 1; i < 4; i++) bus(1'b1, 16'h0030, 8'(i));
    wr(2'd0, 16'h0001);
    chk("R5 arm clear ends run", status, 8'h03);
    bus(1'b1, 16'h0030, 8'h04);
    chk("R5 no store after manual end", status, 8'h03);
    rd("R9 manual read", 1);
    rd("R9 manual read", 2);
    rd("R9 manual read", 3);
    rd("R10 exhausted read", 0);
    wr(2'd0, 16'h0003);
    bus(1'b1, 16'h0030, 8'h09);
    bus(1'b1, 16'h0030, 8'h0A);
    wr(2'd0, 16'h0002);
    chk("R5 enable clear ends run", status, 8'h02);
    rd("R9 read after enable clear", 8'h09);
    rd("R9 read after enable clear", 8'h0A);
  endtask

  task automatic t_valid();
    wr(2'd0, 16'h0003);
    bus(1'b0, 16'h0100, 8'h66);
    chk("R6 invalid cycle ignored", status, 8'h20);
    rd("R10 read while armed", 0);
    chk("R10 read while armed no change", status, 8'h20);
    bus(1'b1, 16'h0100, 8'h77);
    chk("R6 valid hit sets flag and triggers", status, 8'h81);
    rd("R9 single word", 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable_gate();
    wr(2'd1, 16'h0100);
    wr(2'd2, 16'h0200);
    t_begin();
    t_end();
    t_manual();
    t_valid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule